// File: doc/BRIEF.md
# MDIO Management Bus Master

This block carries out PHY management register accesses on the two-wire management bus. A host hands it one request at a time through a valid/ready command port. Each request names the direction, the framing style (Clause 22 or Clause 45), a 5-bit PHY address, a 5-bit register or device address, a 16-bit register address for Clause 45, and 16 bits of write data. When the access is over, the block pulses `rsp_done` for one cycle. At the same time it presents the read result and an error flag.

The management clock is made from the system clock. Each of its half periods lasts `HALF_DIV` system cycles. The clock only runs while a transaction is in flight and sits low otherwise. The bidirectional data line is split into three signals: an output value, an output enable and a sampled input. The master changes what it drives only on the falling edge of the management clock. It samples incoming data at the end of the high half, just before the falling edge.

A Clause 45 access takes two frames. The first is an address frame. The second is the read or write frame, which repeats the same PHY and device fields. For a read frame, the master checks the turnaround bit that the PHY drives. If that bit is wrong, the master runs a fixed flush of released clock cycles and reports an error. The exception is a PHY whose bit is set in the ignore mask.

Top module: `mdio_master`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `mdio_oe_o` and `mdc_o` are 0, `rsp_done` is 0, and `cmd_ready` is 1 once reset is released.
- R2: The high half of `mdc_o` lasts exactly `HALF_DIV` clock cycles. Its low half lasts at least `HALF_DIV` cycles. While the block is idle, `mdc_o` stays low and `mdio_oe_o` stays 0. Read data is taken `HALF_DIV` cycles after the rising edge.
- R3: Every frame opens with 32 driven '1' bits. A Clause 22 frame continues with start bits 0,1, then opcode 1,0 for a read or 0,1 for a write, then the PHY address and the register address, each 5 bits and sent MSB first.
- R4: A Clause 45 access first sends an address frame with start 0,0 and opcode 0,0. It then sends a second frame with start 0,0, opcode 1,1 for a read or 0,1 for a write, and the same PHY and device fields.
- R5: In write frames and address frames, the master drives the turnaround as 1 then 0. It then drives 16 bits MSB first: the write data, or the Clause 45 register address in an address frame.
- R6: In a read frame, `mdio_oe_o` drops after the register/device field (bit 46 of the frame). The master samples one turnaround bit and, if that bit is 0, shifts in 16 data bits MSB first and returns them on `rsp_rdata`. `rsp_rdata` reads 0 after a write.
- R7: If the sampled turnaround bit is 1 and `ta_ignore_mask[phy]` is 0, the master clocks 32 further cycles with the line released. It then answers with `rsp_err`=1 and `rsp_rdata`=0.
- R8: If `ta_ignore_mask[phy]` is 1, the value of the turnaround bit is ignored and the 16 data bits are read as normal, with `rsp_err`=0.
- R9: After the last bit of every frame, the master gives one more MDC cycle with the line released. It holds `mdio_oe_o` at 0 when `rsp_done` pulses.
- R10: `mdio_o` and `mdio_oe_o` change only in cycles where `mdc_o` is low, so the driven value is stable across each rising edge.
- R11: `cmd_ready` is high only while idle. A command is accepted when both `cmd_valid` and `cmd_ready` are high. `cmd_ready` drops in the next cycle and returns together with the single-cycle `rsp_done`. A `cmd_valid` seen while busy has no effect on the frames being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Master idle, command can be taken |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_c45 | input | 1 | 1 = Clause 45 framing, 0 = Clause 22 |
| cmd_phy | input | 5 | PHY address |
| cmd_dev | input | 5 | Register address (Clause 22) or device address (Clause 45) |
| cmd_reg | input | 16 | Clause 45 register address |
| cmd_wdata | input | 16 | Write data |
| ta_ignore_mask | input | 32 | Per-PHY turnaround-check bypass |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Turnaround error on the completed access |
| rsp_rdata | output | 16 | Read result |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The checker watches, on every cycle, the timing relations that hold for any traffic:
- the exact high-half length and the minimum low-half length of the clock;
- data-line changes confined to the low half;
- a quiet line while idle;
- a released line at completion;
- the shape of the handshake and of the completion pulse.

Bit content can only be shown by the bench's scenarios. These cover the exact frame bits, the Clause 45 pairing of address and data frames, and the turnaround decision with and without the mask. They also cover the 32-cycle flush length, the recovered read value and the immunity to commands issued while busy. The bench checks these by logging the line at each rising edge of the clock and comparing the log against frames it builds itself.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;   // preamble through data field
  localparam int HDR_BITS   = 46;   // preamble, start, opcode, two address fields
  localparam int DATA_BITS  = 16;
  localparam int FLUSH_BITS = 32;
  localparam int ADDR_W     = 5;
  localparam int NUM_PHY    = 1 << ADDR_W;

  localparam logic [1:0] START_C22 = 2'b01;
  localparam logic [1:0] START_C45 = 2'b00;
  localparam logic [1:0] OPC_C22_RD = 2'b10;
  localparam logic [1:0] OPC_C22_WR = 2'b01;
  localparam logic [1:0] OPC_C45_AD = 2'b00;
  localparam logic [1:0] OPC_C45_WR = 2'b01;
  localparam logic [1:0] OPC_C45_RD = 2'b11;
  localparam logic [1:0] TURN_DRV   = 2'b10;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic [1:0] st, input logic [1:0] opc,
    input logic [ADDR_W-1:0] phy, input logic [ADDR_W-1:0] dev,
    input logic [DATA_BITS-1:0] payload);
    return {{32{1'b1}}, st, opc, phy, dev, TURN_DRV, payload};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF_DIV = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic bit_end
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap    = (cnt == CW'(HALF_DIV - 1));
  assign bit_end = run && mdc && wrap;   // falling edge follows

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_bit_engine.sv
module mdio_bit_engine
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bit_end,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] frame_in,
  input  logic                  rd_frame,
  input  logic                  ta_ignore,
  input  logic                  mdio_i,
  output logic                  mdo,
  output logic                  mdoe,
  output logic                  busy,
  output logic                  fdone,
  output logic                  ferr,
  output logic [DATA_BITS-1:0]  rdata
);
  localparam int CNT_W = $clog2(FRAME_BITS);

  typedef enum logic [2:0] {E_IDLE, E_TX, E_TA, E_RX, E_FLUSH, E_TAIL} eng_state_t;

  eng_state_t            st;
  logic [FRAME_BITS-1:0] shreg;
  logic [CNT_W-1:0]      cnt;
  logic                  rd_q;
  logic                  ign_q;
  logic [CNT_W-1:0]      last_tx;

  assign busy    = (st != E_IDLE);
  assign last_tx = rd_q ? CNT_W'(HDR_BITS - 1) : CNT_W'(FRAME_BITS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= E_IDLE;
      shreg <= '0;
      cnt   <= '0;
      rd_q  <= 1'b0;
      ign_q <= 1'b0;
      mdo   <= 1'b0;
      mdoe  <= 1'b0;
      fdone <= 1'b0;
      ferr  <= 1'b0;
      rdata <= '0;
    end else begin
      fdone <= 1'b0;
      case (st)
        E_IDLE: if (start) begin
          shreg <= frame_in;
          mdo   <= frame_in[FRAME_BITS-1];
          mdoe  <= 1'b1;
          cnt   <= '0;
          rd_q  <= rd_frame;
          ign_q <= ta_ignore;
          ferr  <= 1'b0;
          st    <= E_TX;
        end
        E_TX: if (bit_end) begin
          if (cnt == last_tx) begin
            mdoe <= 1'b0;
            mdo  <= 1'b0;
            cnt  <= '0;
            st   <= rd_q ? E_TA : E_TAIL;
          end else begin
            cnt   <= cnt + 1'b1;
            shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
            mdo   <= shreg[FRAME_BITS-2];
          end
        end
        E_TA: if (bit_end) begin
          cnt <= '0;
          if (mdio_i && !ign_q) begin
            ferr <= 1'b1;
            st   <= E_FLUSH;
          end else begin
            st <= E_RX;
          end
        end
        E_RX: if (bit_end) begin
          rdata <= {rdata[DATA_BITS-2:0], mdio_i};
          if (cnt == CNT_W'(DATA_BITS - 1)) st <= E_TAIL;
          else cnt <= cnt + 1'b1;
        end
        E_FLUSH: if (bit_end) begin
          if (cnt == CNT_W'(FLUSH_BITS - 1)) st <= E_TAIL;
          else cnt <= cnt + 1'b1;
        end
        E_TAIL: if (bit_end) begin
          fdone <= 1'b1;
          st    <= E_IDLE;
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 40
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic                 cmd_read,
  input  logic                 cmd_c45,
  input  logic [ADDR_W-1:0]    cmd_phy,
  input  logic [ADDR_W-1:0]    cmd_dev,
  input  logic [DATA_BITS-1:0] cmd_reg,
  input  logic [DATA_BITS-1:0] cmd_wdata,
  input  logic [NUM_PHY-1:0]   ta_ignore_mask,
  output logic                 rsp_done,
  output logic                 rsp_err,
  output logic [DATA_BITS-1:0] rsp_rdata,
  output logic                 mdc_o,
  output logic                 mdio_o,
  output logic                 mdio_oe_o,
  input  logic                 mdio_i
);
  typedef enum logic [1:0] {T_IDLE, T_ADDR, T_DATA} txn_state_t;

  txn_state_t            tst;
  logic                  q_read, q_c45;
  logic [ADDR_W-1:0]     q_phy, q_dev;
  logic [DATA_BITS-1:0]  q_wdata;
  logic                  start_q, rdfrm_q;
  logic [FRAME_BITS-1:0] frame_q;
  logic                  bit_end, eng_busy, fdone, ferr;
  logic [DATA_BITS-1:0]  eng_rdata;

  function automatic logic [FRAME_BITS-1:0] data_frame(
    input logic c45, input logic rd, input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] dev, input logic [DATA_BITS-1:0] wd);
    logic [1:0] st, opc;
    st  = c45 ? START_C45 : START_C22;
    opc = c45 ? (rd ? OPC_C45_RD : OPC_C45_WR) : (rd ? OPC_C22_RD : OPC_C22_WR);
    return build_frame(st, opc, phy, dev, wd);
  endfunction

  assign cmd_ready = (tst == T_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      tst       <= T_IDLE;
      q_read    <= 1'b0;
      q_c45     <= 1'b0;
      q_phy     <= '0;
      q_dev     <= '0;
      q_wdata   <= '0;
      start_q   <= 1'b0;
      rdfrm_q   <= 1'b0;
      frame_q   <= '0;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      start_q  <= 1'b0;
      rsp_done <= 1'b0;
      case (tst)
        T_IDLE: if (cmd_valid) begin
          q_read  <= cmd_read;
          q_c45   <= cmd_c45;
          q_phy   <= cmd_phy;
          q_dev   <= cmd_dev;
          q_wdata <= cmd_wdata;
          start_q <= 1'b1;
          if (cmd_c45) begin
            frame_q <= build_frame(START_C45, OPC_C45_AD, cmd_phy, cmd_dev, cmd_reg);
            rdfrm_q <= 1'b0;
            tst     <= T_ADDR;
          end else begin
            frame_q <= data_frame(1'b0, cmd_read, cmd_phy, cmd_dev, cmd_wdata);
            rdfrm_q <= cmd_read;
            tst     <= T_DATA;
          end
        end
        T_ADDR: if (fdone) begin
          frame_q <= data_frame(q_c45, q_read, q_phy, q_dev, q_wdata);
          rdfrm_q <= q_read;
          start_q <= 1'b1;
          tst     <= T_DATA;
        end
        T_DATA: if (fdone) begin
          rsp_done  <= 1'b1;
          rsp_err   <= ferr;
          rsp_rdata <= (q_read && !ferr) ? eng_rdata : '0;
          tst       <= T_IDLE;
        end
        default: tst <= T_IDLE;
      endcase
    end
  end

  mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_gen (
    .clk     (clk),
    .rst     (rst),
    .run     (eng_busy),
    .mdc     (mdc_o),
    .bit_end (bit_end)
  );

  mdio_bit_engine u_eng (
    .clk       (clk),
    .rst       (rst),
    .bit_end   (bit_end),
    .start     (start_q),
    .frame_in  (frame_q),
    .rd_frame  (rdfrm_q),
    .ta_ignore (ta_ignore_mask[q_phy]),
    .mdio_i    (mdio_i),
    .mdo       (mdio_o),
    .mdoe      (mdio_oe_o),
    .busy      (eng_busy),
    .fdone     (fdone),
    .ferr      (ferr),
    .rdata     (eng_rdata)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int HALF_DIV = 40
) (
  input logic clk,
  input logic rst,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic rsp_done,
  input logic mdc_o,
  input logic mdio_o,
  input logic mdio_oe_o
);
  localparam int HW = $clog2(HALF_DIV + 2) + 1;

  logic          mdc_d;
  logic [HW-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_d <= 1'b0;
      hcnt  <= HW'(HALF_DIV);
    end else begin
      mdc_d <= mdc_o;
      if (mdc_o != mdc_d) hcnt <= HW'(1);
      else if (hcnt != '1) hcnt <= hcnt + 1'b1;
    end
  end

  AST_HIGH_HALF: assert property (@(posedge clk) disable iff (rst)
    (!mdc_o && mdc_d) |-> (hcnt == HW'(HALF_DIV))); // R2
  AST_LOW_HALF: assert property (@(posedge clk) disable iff (rst)
    (mdc_o && !mdc_d) |-> (hcnt >= HW'(HALF_DIV))); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (!mdc_o && !mdio_oe_o)); // R2
  AST_DRIVE_ON_LOW: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mdio_o) || !$stable(mdio_oe_o)) |-> !mdc_o); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R11
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R11
  AST_TAIL_RELEASED: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> !mdio_oe_o); // R9
endmodule

bind mdio_master mdio_master_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .rsp_done  (rsp_done),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int HALF = 3;
  localparam int LOGN = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_read = 1'b0, cmd_c45 = 1'b0;
  logic        cmd_ready;
  logic [4:0]  cmd_phy = '0, cmd_dev = '0;
  logic [15:0] cmd_reg = '0, cmd_wdata = '0;
  logic [31:0] mask = 32'h8000_0010;
  logic        rsp_done, rsp_err;
  logic [15:0] rsp_rdata;
  logic        mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i = 1'b1;

  mdio_master #(.HALF_DIV(HALF)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_read(cmd_read), .cmd_c45(cmd_c45), .cmd_phy(cmd_phy), .cmd_dev(cmd_dev),
    .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .ta_ignore_mask(mask),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i));

  int n_chk = 0, n_bad = 0;
  bit fin = 1'b0;
  logic exp_oe [LOGN];
  logic exp_bit[LOGN];
  int   exp_cat[LOGN];
  logic log_oe [LOGN];
  logic log_bit[LOGN];
  logic resp   [LOGN];
  int   rc = 0, n_exp = 0;

  // PHY side: log the line at each rising edge, present response bits on falling edges
  always @(posedge mdc_o) begin
    if (rc < LOGN) begin
      log_oe[rc]  = mdio_oe_o;
      log_bit[rc] = mdio_o;
    end
    rc++;
  end
  always @(negedge mdc_o) mdio_i <= (rc < LOGN) ? resp[rc] : 1'b1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] frm(input logic [1:0] st, input logic [1:0] op,
                                      input logic [4:0] p, input logic [4:0] d, input logic [15:0] v);
    return {32'hFFFF_FFFF, st, op, p, d, 2'b10, v};
  endfunction

  task automatic push(input logic [63:0] f, input int ndrv, input int nrel);
    for (int i = 0; i < ndrv; i++) begin
      exp_oe[n_exp] = 1'b1; exp_bit[n_exp] = f[63-i]; exp_cat[n_exp] = (i < 46) ? 0 : 1; n_exp++;
    end
    for (int i = 0; i < nrel; i++) begin
      exp_oe[n_exp] = 1'b0; exp_bit[n_exp] = 1'b0; exp_cat[n_exp] = 2; n_exp++;
    end
  endtask

  task automatic txn(input bit c45, input bit rd, input logic [4:0] p, input logic [4:0] d,
                     input logic [15:0] rg, input logic [15:0] wv, input logic [15:0] rv, input bit tabad);
    bit bad, busy_ok;
    int guard;
    int mm[3];
    logic [1:0] st, op;
    logic [15:0] exp_rd;
    n_exp = 0;
    for (int i = 0; i < LOGN; i++) resp[i] = 1'b1;
    bad = rd && tabad && !mask[p];
    st  = c45 ? 2'b00 : 2'b01;
    op  = c45 ? (rd ? 2'b11 : 2'b01) : (rd ? 2'b10 : 2'b01);
    if (c45) push(frm(2'b00, 2'b00, p, d, rg), 64, 1);
    if (rd) begin
      push(frm(st, op, p, d, 16'h0), 46, 0);
      resp[n_exp] = tabad;
      for (int i = 0; i < 16; i++) resp[n_exp+1+i] = rv[15-i];
      push(64'h0, 0, bad ? 34 : 18);
    end else begin
      push(frm(st, op, p, d, wv), 64, 1);
    end
    exp_rd = (rd && !bad) ? rv : 16'h0;

    @(negedge clk);
    rc = 0;
    cmd_valid = 1'b1; cmd_c45 = c45; cmd_read = rd; cmd_phy = p; cmd_dev = d;
    cmd_reg = rg; cmd_wdata = wv;
    @(negedge clk);
    // R11: a request offered while busy must not be taken nor alter the frames
    cmd_c45 = ~c45; cmd_read = ~rd; cmd_phy = ~p; cmd_dev = ~d; cmd_reg = ~rg; cmd_wdata = ~wv;
    busy_ok = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (cmd_ready) busy_ok = 1'b0;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk(busy_ok, "R11 ready low while busy", {31'h0, !busy_ok}, 32'h0);

    guard = 0;
    while (!rsp_done && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk(rsp_done, "R11 done pulse", {31'h0, rsp_done}, 32'h1);
    chk(rsp_err == bad, bad ? "R7 error flag" : (tabad ? "R8 masked turnaround" : "R6 no error"),
        {31'h0, rsp_err}, {31'h0, bad});
    chk(rsp_rdata == exp_rd, bad ? "R7 read data" : (tabad ? "R8 read data" : "R6 read data"),
        {16'h0, rsp_rdata}, {16'h0, exp_rd});
    chk(rc == n_exp, bad ? "R7 flush length" : "R9 clock count", rc, n_exp);
    mm[0] = 0; mm[1] = 0; mm[2] = 0;
    for (int i = 0; i < n_exp && i < LOGN; i++) begin
      if (log_oe[i] !== exp_oe[i]) mm[exp_cat[i]]++;
      else if (exp_oe[i] && log_bit[i] !== exp_bit[i]) mm[exp_cat[i]]++;
    end
    chk(mm[0] == 0, c45 ? "R4 header bits" : "R3 header bits", mm[0], 0);
    if (!rd || c45) chk(mm[1] == 0, "R5 turnaround and data bits", mm[1], 0);
    chk(mm[2] == 0, rd ? "R6 released bits" : "R9 released bits", mm[2], 0);
    @(negedge clk);
    chk(!rsp_done && cmd_ready, "R11 single done and ready", {30'h0, rsp_done, cmd_ready}, 32'h1);
    chk(!mdc_o && !mdio_oe_o, "R2 idle line", {30'h0, mdc_o, mdio_oe_o}, 32'h0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk(!mdio_oe_o && !mdc_o && !rsp_done, "R1 reset outputs", {29'h0, mdio_oe_o, mdc_o, rsp_done}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_ready && !mdio_oe_o && !mdc_o, "R1 idle after reset", {29'h0, cmd_ready, mdio_oe_o, mdc_o}, 32'h4);

    txn(1'b0, 1'b0, 5'h01, 5'h02, 16'h0,    16'hA55A, 16'h0,    1'b0); // R3 R5 write
    txn(1'b0, 1'b1, 5'h03, 5'h1F, 16'h0,    16'h0,    16'h8001, 1'b0); // R6 read
    txn(1'b0, 1'b1, 5'h02, 5'h04, 16'h0,    16'h0,    16'hFFFF, 1'b1); // R7 bad TA
    txn(1'b0, 1'b1, 5'h04, 5'h00, 16'h0,    16'h0,    16'h1234, 1'b1); // R8 masked
    txn(1'b0, 1'b1, 5'h1F, 5'h15, 16'h0,    16'h0,    16'h0000, 1'b1); // R8 top PHY
    txn(1'b1, 1'b0, 5'h1F, 5'h1E, 16'hBEEF, 16'h0000, 16'h0,    1'b0); // R4 write
    txn(1'b1, 1'b1, 5'h00, 5'h01, 16'hFFFF, 16'h0,    16'h00FF, 1'b0); // R4 read
    txn(1'b1, 1'b1, 5'h06, 5'h03, 16'h0001, 16'h0,    16'hAAAA, 1'b1); // R7 C45
    for (int k = 0; k < 20; k++) begin
      logic [31:0] r;
      r = $urandom;
      txn(r[0], r[1], r[6:2], r[11:7], $urandom, $urandom, $urandom, (r[13:12] == 2'b00));
    end
    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!fin) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule